// File: doc/BRIEF.md
# Script Register ALU Instruction Unit

This unit carries out one register read/modify/write instruction of a 32-bit script instruction stream. It sits beside a byte-wide register file and owns two pieces of architectural state: the first-byte register (SFBR) and a carry flag. The instruction word arrives with a start strobe. The unit decodes the word and reads the addressed register through an asynchronous read port. It then applies one of eight byte operations and routes the result to the register file or to SFBR. A one-cycle done pulse marks the end of the instruction.

Three routing modes decide where the operands come from:

- **Out of SFBR:** SFBR and the immediate are combined, and the result goes to the addressed register.
- **Into SFBR:** the addressed register and the immediate are combined, and the result goes to SFBR.
- **In place:** the register is combined with either the immediate or SFBR, and the result goes back to the same register.

The shifts and add-with-carry chain through the carry flag, so multi-byte arithmetic can be built from a sequence of instructions. Opcode values outside these three modes are flagged as illegal and leave all state untouched.

Top module: `sreg_alu`

## Requirements
- R1: After reset, `sfbr` is 0x00 and `carry`, `done`, `illegal` and `rf_we` are all 0.
- R2: A `start` seen while idle latches `insn`. In the next cycle the unit drives `rf_addr` and, when a write is due, asserts `rf_we` with `rf_wdata`. `done` is high for exactly one cycle after that, and the new `sfbr` and `carry` become visible at the same time. A `start` seen while busy is ignored.
- R3: Decoding is as follows. The register address is `{insn[7], insn[22:16]}`, so `insn[7]` is the address MSB. The immediate is `insn[15:8]`. The opcode is `insn[29:27]`. The operator is `insn[26:24]`.
- R4: Opcode 5 uses SFBR as the first operand and the immediate as the second, and writes the result to the addressed register. SFBR is not changed.
- R5: Opcode 6 uses the addressed register as the first operand and the immediate as the second, and writes the result to SFBR. No register-file write takes place.
- R6: Opcode 7 uses the addressed register as the first operand and writes the result back to that register. The second operand is SFBR when `insn[23]` is 1, and the immediate otherwise.
- R7: Operator 0 (move) yields the second operand. Operators 2, 3 and 4 yield the OR, XOR and AND of the two operands. None of these four changes `carry`.
- R8: Operator 1 shifts the first operand left, with the old carry entering bit 0; the new carry is the old bit 7. Operator 5 shifts it right, with the old carry entering bit 7; the new carry is the old bit 0.
- R9: Operator 6 produces the 8-bit sum of the two operands. It sets `carry` when that sum is less than the second operand, which is the same as an unsigned overflow.
- R10: Operator 7 produces the 8-bit sum of both operands plus the old carry. The new carry is 1 when the sum is less than or equal to the second operand if the old carry was 1, and when it is strictly less if the old carry was 0.
- R11: Opcodes 0 to 4 produce a `done` pulse with `illegal` high. There is no register write, and `sfbr` and `carry` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction valid strobe |
| insn | input | 32 | Instruction word |
| rf_addr | output | 8 | Register file address |
| rf_rdata | input | 8 | Register file read data (combinational from `rf_addr`) |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | 8 | Register file write data |
| sfbr | output | 8 | First-byte register |
| carry | output | 1 | Carry flag |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal-opcode flag, valid with `done` |

## Verification
The assertions check the following on every cycle:

- the one-cycle busy window and the single-cycle `done` pulse;
- that register writes and SFBR changes happen only in a legal instruction's completion window;
- that illegal opcodes and the move and logic operators leave the carry untouched.

Only the bench scenarios can show the result values. These include the arithmetic of each operator under each routing mode, carry chaining across consecutive shifts and adds, the split address landing on the right byte, and a held start being taken only once.

// File: rtl/sreg_alu.sv
module sreg_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] insn,
  output logic [7:0]  rf_addr,
  input  logic [7:0]  rf_rdata,
  output logic        rf_we,
  output logic [7:0]  rf_wdata,
  output logic [7:0]  sfbr,
  output logic        carry,
  output logic        done,
  output logic        illegal
);
  localparam logic [2:0] OPC_FROM = 3'd5;
  localparam logic [2:0] OPC_TO   = 3'd6;
  localparam logic [2:0] OPC_RMW  = 3'd7;

  logic        busy;
  logic [31:0] iq;
  logic [7:0]  res;
  logic        cout;

  wire [2:0] opc   = iq[29:27];
  wire [2:0] oper  = iq[26:24];
  wire [7:0] imm   = iq[15:8];
  wire       legal = (opc == OPC_FROM) || (opc == OPC_TO) || (opc == OPC_RMW);
  wire [7:0] opa   = (opc == OPC_FROM) ? sfbr : rf_rdata;
  wire [7:0] opb   = (opc == OPC_RMW && iq[23]) ? sfbr : imm;

  assign rf_addr  = {iq[7], iq[22:16]};
  assign rf_we    = busy && legal && (opc != OPC_TO);
  assign rf_wdata = res;

  always_comb begin
    res  = opb;
    cout = carry;
    case (oper)
      3'd0: res = opb;
      3'd1: {cout, res} = {opa, carry};
      3'd2: res = opa | opb;
      3'd3: res = opa ^ opb;
      3'd4: res = opa & opb;
      3'd5: begin res = {carry, opa[7:1]}; cout = opa[0]; end
      3'd6: {cout, res} = {1'b0, opa} + {1'b0, opb};
      default: {cout, res} = {1'b0, opa} + {1'b0, opb} + {8'd0, carry};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      iq      <= '0;
      sfbr    <= '0;
      carry   <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= busy;
      illegal <= busy && !legal;
      if (busy) begin
        busy <= 1'b0;
        if (legal) begin
          carry <= cout;
          if (opc == OPC_TO) sfbr <= res;
        end
      end else if (start) begin
        busy <= 1'b1;
        iq   <= insn;
      end
    end
  end
endmodule

module sreg_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        illegal,
  input logic        rf_we,
  input logic [7:0]  sfbr,
  input logic        carry,
  input logic [31:0] iq
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && done));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_we_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> (done && !illegal));
  p_sfbr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sfbr) |-> (done && !illegal));
  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> ($stable(sfbr) && $stable(carry)));
  p_logic_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (iq[26:24] == 3'd0 || iq[26:24] == 3'd2 || iq[26:24] == 3'd3 || iq[26:24] == 3'd4))
      |-> $stable(carry));
endmodule

bind sreg_alu sreg_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .illegal(illegal), .rf_we(rf_we), .sfbr(sfbr), .carry(carry), .iq(iq)
);

// File: tb/sreg_alu_tb.sv
module sreg_alu_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [31:0] insn = '0;
  logic [7:0]  rf_addr, rf_wdata, sfbr;
  logic        rf_we, carry, done, illegal;
  logic [7:0]  mem [256];
  int          checks = 0, errors = 0, we_cnt = 0;
  logic [7:0]  e_sfbr = 0;
  logic        e_c = 0;

  always #10 clk = ~clk;

  wire [7:0] rf_rdata = mem[rf_addr];

  always @(posedge clk) begin
    if (rf_we) begin
      mem[rf_addr] <= rf_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  sreg_alu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .rf_addr(rf_addr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata), .sfbr(sfbr),
    .carry(carry), .done(done), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int opc, input int op, input int b23,
                                     input logic [7:0] addr, input logic [7:0] imm);
    logic [31:0] w = '0;
    w[31:30] = 2'b01;
    w[29:27] = opc[2:0];
    w[26:24] = op[2:0];
    w[23]    = b23[0];
    w[22:16] = addr[6:0];
    w[15:8]  = imm;
    w[7]     = addr[7];
    return w;
  endfunction

  task automatic alu(input int op, input int a, input int b, input int cin,
                     output int r, output int cout);
    int s;
    cout = cin;
    case (op)
      0: s = b;
      1: begin s = a * 2 + cin; cout = (a >= 128) ? 1 : 0; end
      2: s = a | b;
      3: s = a ^ b;
      4: s = a & b;
      5: begin s = a / 2 + cin * 128; cout = a % 2; end
      6: begin s = a + b; cout = (s > 255) ? 1 : 0; end
      default: begin s = a + b + cin; cout = (s > 255) ? 1 : 0; end
    endcase
    r = s % 256;
  endtask

  task automatic run(input int opc, input int op, input int b23,
                     input logic [7:0] addr, input logic [7:0] imm);
    int a, b, r, c, we0;
    logic [7:0] e_mem, other;
    string tag;
    tag = (opc == 5) ? "R4" : (opc == 6) ? "R5" : "R6";
    a = (opc == 5) ? int'(e_sfbr) : int'(mem[addr]);
    b = (opc == 7 && b23 == 1) ? int'(e_sfbr) : int'(imm);
    alu(op, a, b, int'(e_c), r, c);
    e_mem = (opc == 6) ? mem[addr] : r[7:0];
    other = mem[addr ^ 8'h80];
    we0 = we_cnt;
    @(negedge clk); start = 1; insn = mk(opc, op, b23, addr, imm);
    @(negedge clk); start = 0;
    @(negedge clk);
    if (opc == 6) e_sfbr = r[7:0];
    if (op == 1 || op == 5) begin
      chk(carry == c[0], "R8 carry", carry, c);
    end else if (op >= 6) begin
      chk(carry == c[0], (op == 6) ? "R9 carry" : "R10 carry", carry, c);
    end else begin
      chk(carry == c[0], "R7 carry kept", carry, c);
    end
    e_c = c[0];
    chk(done === 1'b1 && illegal === 1'b0, "R2 done", {done, illegal}, 2);
    chk(sfbr == e_sfbr, tag, sfbr, e_sfbr);
    chk(mem[addr] == e_mem, tag, mem[addr], e_mem);
    chk(mem[addr ^ 8'h80] == other, "R3 address msb", mem[addr ^ 8'h80], other);
    chk((we_cnt - we0) == ((opc == 6) ? 0 : 1), "R5 write count", we_cnt - we0, (opc == 6) ? 0 : 1);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(sfbr == 0 && carry == 0 && done == 0 && illegal == 0 && rf_we == 0,
        "R1 reset", {sfbr, carry, done, illegal, rf_we}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R5 R6 R7 R8 R9 R10: sweep routing, operators, bit 23
    for (int opc = 5; opc <= 7; opc++)
      for (int op = 0; op < 8; op++)
        for (int b23 = 0; b23 < 2; b23++)
          for (int n = 0; n < 12; n++) begin
            logic [7:0] ad, im;
            ad = 8'($urandom);
            im = 8'($urandom);
            if (n == 0) im = 8'hFF;
            if (n == 1) im = 8'h00;
            if (n == 2) mem[ad] = 8'hFF;
            if (n == 3) ad[7] = 1'b1;
            run(opc, op, b23, ad, im);
          end

    // R10: carry chaining at the equality boundary
    run(6, 0, 0, 8'h10, 8'hFF);
    run(6, 6, 0, 8'h10, 8'hFF);
    mem[8'h90] = 8'h00;
    run(7, 7, 1, 8'h90, 8'h00);
    run(7, 7, 0, 8'h90, 8'hFF);

    // R11: illegal opcodes leave state alone
    for (int opc = 0; opc < 5; opc++)
      for (int op = 0; op < 8; op++) begin
        int we0;
        logic [7:0] m0, s0;
        logic c0;
        m0 = mem[8'h85]; s0 = sfbr; c0 = carry; we0 = we_cnt;
        @(negedge clk); start = 1; insn = mk(opc, op, 1, 8'h85, 8'h5A);
        @(negedge clk); start = 0;
        @(negedge clk);
        chk(done && illegal, "R11 flag", {done, illegal}, 3);
        chk(sfbr == s0 && carry == c0, "R11 state", {sfbr, carry}, {s0, c0});
        chk(mem[8'h85] == m0 && we_cnt == we0, "R11 no write", mem[8'h85], m0);
      end

    // R2: held start accepted once
    begin
      logic [7:0] m0;
      mem[8'h22] = 8'h40; m0 = 8'h41;
      @(negedge clk); start = 1; insn = mk(7, 0, 0, 8'h22, 8'h00) | 32'h0600_0100;
      @(negedge clk);
      @(negedge clk); start = 0;
      chk(done == 1'b1, "R2 done after hold", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R2 held start ignored", done, 0);
      chk(mem[8'h22] == m0, "R2 single execution", mem[8'h22], m0);
      @(negedge clk);
      chk(done == 1'b0, "R2 no second done", done, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule